// File: doc/BRIEF.md
# Oversampled Bit Voter with Programmable Tolerance

This block judges one received asynchronous bit from thirty-two samples of the serial line, all taken inside a bit window. Another block finds the start bit and produces the window-start pulse and a sample strobe that runs at thirty-two times the bit rate. This block counts how many of the strobed samples were HIGH. When the window is full it gives a three-way verdict: HIGH, LOW, or error.

The verdict is not a plain majority vote. A two-bit tolerance code sets how many samples may disagree with the decided level. A bit is HIGH when the LOW samples stay within that limit, and LOW when the HIGH samples stay within it. In every other case the samples are too mixed to trust, and the bit is flagged as an error. The surrounding receiver uses the valid pulse to take each decided bit into its own message logic.

Top module: `bitvote_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bit_valid`, `bit_value` and `bit_error` are all 0.
- R2: Sample strobes that arrive after reset but before any `win_start` pulse are ignored, and no `bit_valid` is produced.
- R3: After a `win_start` pulse, exactly 32 strobed samples make one `bit_valid` pulse. The pulse lasts one cycle and is high in the second cycle after the clock edge that captured the 32nd strobe (one register stage follows the sample counter).
- R4: The tolerance code on `tol_sel` gives the largest number of disagreeing samples out of 32: 0 gives 6, 1 gives 8, 2 gives 10 and 3 gives 12. `tol_sel` is read in the cycle the verdict is registered.
- R5: If the number of LOW samples is at most the limit, the verdict is HIGH: `bit_value`=1 and `bit_error`=0.
- R6: If the number of HIGH samples is at most the limit, the verdict is LOW: `bit_value`=0 and `bit_error`=0.
- R7: If neither count is within the limit, the verdict is error: `bit_error`=1 and `bit_value`=0.
- R8: A `win_start` pulse in the middle of a window throws away the samples counted so far. The next verdict uses only the 32 samples strobed after the new pulse.
- R9: A strobe in the same cycle as `win_start` is not counted as a sample.
- R10: The line is read only in cycles where the strobe is high. The line level in other cycles has no effect on the verdict.
- R11: Strobes that arrive after the 32nd sample and before the next `win_start` are ignored and make no further `bit_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Serial line, already synchronized to clk |
| smp_strobe | input | 1 | Sample enable, one cycle wide, at 32 times the bit rate |
| win_start | input | 1 | Starts a new bit window and clears the counts |
| tol_sel | input | 2 | Tolerance code (0..3) |
| bit_valid | output | 1 | One-cycle pulse when a verdict is ready |
| bit_value | output | 1 | Decided level; 1 only for a HIGH verdict |
| bit_error | output | 1 | Set when the samples are too mixed to decide |

## Verification
The assertions assume that `tol_sel` stays steady from the last sample of a window until the verdict is registered. They also assume that `win_start` and the strobe are clean single-cycle pulses on the clock. The stimulus changes the tolerance only when it raises the window-start pulse. It keeps every strobe one cycle wide, and it drives the line and the strobes on the falling clock edge. The sequences with restarted windows, strobes that coincide with a window start, and extra strobes after a window still stay within these assumptions.

// File: rtl/bitvote_pkg.sv
package bitvote_pkg;

    localparam int unsigned VOTE_SAMPLES = 32;

    typedef enum logic [1:0] {
        TOL_NARROW = 2'd0,
        TOL_MID    = 2'd1,
        TOL_WIDE   = 2'd2,
        TOL_WIDEST = 2'd3
    } tol_e;

    typedef enum logic [1:0] {
        VERD_LOW  = 2'd0,
        VERD_HIGH = 2'd1,
        VERD_ERR  = 2'd2
    } verdict_e;

    typedef struct packed {
        logic valid;
        logic value;
        logic err;
    } bitres_t;

    // Largest number of disagreeing samples for a tolerance code,
    // scaled from the 32-sample base of 6/8/10/12.
    function automatic int unsigned tol_limit(input logic [1:0] sel,
                                              input int unsigned samples);
        return ((32'd6 + 32'd2 * 32'(sel)) * samples) / 32'd32;
    endfunction

endpackage

// File: rtl/bitvote_tally.sv
module bitvote_tally #(
    parameter int unsigned SAMPLES = bitvote_pkg::VOTE_SAMPLES,
    localparam int unsigned CW     = $clog2(SAMPLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_in,
    input  logic          smp_strobe,
    input  logic          win_start,
    output logic [CW-1:0] hi_cnt,
    output logic          win_full
);

    logic          armed;
    logic [CW-1:0] smp_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            smp_cnt  <= '0;
            hi_cnt   <= '0;
            win_full <= 1'b0;
        end else begin
            win_full <= 1'b0;
            if (win_start) begin
                armed   <= 1'b1;
                smp_cnt <= '0;
                hi_cnt  <= '0;
            end else if (armed && smp_strobe) begin
                smp_cnt <= smp_cnt + 1'b1;
                hi_cnt  <= hi_cnt + CW'(line_in);
                if (smp_cnt == CW'(SAMPLES - 1)) begin
                    win_full <= 1'b1;
                    armed    <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/bitvote_judge.sv
module bitvote_judge #(
    parameter int unsigned SAMPLES = bitvote_pkg::VOTE_SAMPLES,
    localparam int unsigned CW     = $clog2(SAMPLES + 1)
) (
    input  logic [CW-1:0]         hi_cnt,
    input  logic [1:0]            tol_sel,
    output bitvote_pkg::verdict_e verdict
);
    import bitvote_pkg::*;

    logic [CW-1:0] lo_cnt;
    logic [CW-1:0] limit;

    always_comb begin
        lo_cnt = CW'(SAMPLES) - hi_cnt;
        limit  = CW'(tol_limit(tol_sel, SAMPLES));
        if (lo_cnt <= limit)
            verdict = VERD_HIGH;
        else if (hi_cnt <= limit)
            verdict = VERD_LOW;
        else
            verdict = VERD_ERR;
    end

endmodule

// File: rtl/bitvote_top.sv
module bitvote_top #(
    parameter int unsigned SAMPLES = bitvote_pkg::VOTE_SAMPLES,
    localparam int unsigned CW     = $clog2(SAMPLES + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_in,
    input  logic       smp_strobe,
    input  logic       win_start,
    input  logic [1:0] tol_sel,
    output logic       bit_valid,
    output logic       bit_value,
    output logic       bit_error
);
    import bitvote_pkg::*;

    logic [CW-1:0] hi_cnt;
    logic          win_full;
    verdict_e      verdict;
    bitres_t       res_q;

    bitvote_tally #(.SAMPLES(SAMPLES)) u_tally (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line_in),
        .smp_strobe (smp_strobe),
        .win_start  (win_start),
        .hi_cnt     (hi_cnt),
        .win_full   (win_full)
    );

    bitvote_judge #(.SAMPLES(SAMPLES)) u_judge (
        .hi_cnt  (hi_cnt),
        .tol_sel (tol_sel),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= win_full;
            if (win_full) begin
                res_q.value <= (verdict == VERD_HIGH);
                res_q.err   <= (verdict == VERD_ERR);
            end
        end
    end

    assign bit_valid = res_q.valid;
    assign bit_value = res_q.value;
    assign bit_error = res_q.err;

endmodule

// File: rtl/bitvote_chk.sv
module bitvote_chk #(
    parameter int unsigned SAMPLES = bitvote_pkg::VOTE_SAMPLES,
    localparam int unsigned CW     = $clog2(SAMPLES + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          smp_strobe,
    input logic          win_start,
    input logic [1:0]    tol_sel,
    input logic          bit_valid,
    input logic          bit_value,
    input logic          bit_error,
    input logic [CW-1:0] hi_cnt
);
    import bitvote_pkg::*;

    logic          ref_armed;
    logic [CW-1:0] ref_cnt;
    logic          last_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_armed <= 1'b0;
            ref_cnt   <= '0;
            last_seen <= 1'b0;
        end else begin
            last_seen <= 1'b0;
            if (win_start) begin
                ref_armed <= 1'b1;
                ref_cnt   <= '0;
            end else if (ref_armed && smp_strobe) begin
                ref_cnt <= ref_cnt + 1'b1;
                if (ref_cnt == CW'(SAMPLES - 1)) begin
                    last_seen <= 1'b1;
                    ref_armed <= 1'b0;
                end
            end
        end
    end

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |=> !bit_valid);                                          // R3
    AST_VALID_FOLLOWS_LAST: assert property (@(posedge clk) disable iff (rst)
        last_seen |=> bit_valid);                                           // R3
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(last_seen));                                    // R2
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> !(bit_value && bit_error));                           // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        32'(hi_cnt) <= SAMPLES);                                            // R11
    AST_HIGH_IN_TOL: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_value) |->
            (SAMPLES - 32'($past(hi_cnt))) <= tol_limit($past(tol_sel), SAMPLES)); // R5
    AST_LOW_IN_TOL: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_value && !bit_error) |->
            32'($past(hi_cnt)) <= tol_limit($past(tol_sel), SAMPLES));     // R6

endmodule

bind bitvote_top bitvote_chk #(.SAMPLES(SAMPLES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_strobe (smp_strobe),
    .win_start  (win_start),
    .tol_sel    (tol_sel),
    .bit_valid  (bit_valid),
    .bit_value  (bit_value),
    .bit_error  (bit_error),
    .hi_cnt     (hi_cnt)
);

// File: tb/bitvote_top_test.sv
module bitvote_top_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       line_in;
    logic       smp_strobe;
    logic       win_start;
    logic [1:0] tol_sel;
    logic       bit_valid;
    logic       bit_value;
    logic       bit_error;

    int vectors = 0;
    int misses  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    typedef struct {
        logic  value;
        logic  err;
        int    cyc;
        string req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;   // 50 MHz

    always @(posedge clk) cyc <= cyc + 1;

    bitvote_top uut (
        .clk        (clk),
        .rst        (rst),
        .line_in    (line_in),
        .smp_strobe (smp_strobe),
        .win_start  (win_start),
        .tol_sel    (tol_sel),
        .bit_valid  (bit_valid),
        .bit_value  (bit_value),
        .bit_error  (bit_error)
    );

    // Monitor: pops the scoreboard on every verdict
    always @(negedge clk) begin
        if (!rst && bit_valid) begin
            vectors++;
            if (sb.size() == 0) begin
                misses++;
                $display("FAIL R2/R11 unexpected valid at cycle %0d: got 1 expected 0", cyc);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (bit_value !== e.value || bit_error !== e.err || cyc != e.cyc) begin
                    misses++;
                    $display("FAIL %s value/err/cycle got %0b/%0b/%0d expected %0b/%0b/%0d",
                             e.req, bit_value, bit_error, cyc, e.value, e.err, e.cyc);
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            misses++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    function automatic logic pat_bit(int pat, int n_hi, int i);
        case (pat)
            0: return logic'(i < n_hi);
            1: return logic'(i >= 32 - n_hi);
            default: return logic'(((i * n_hi) / 32) != (((i + 1) * n_hi) / 32));
        endcase
    endfunction

    task automatic push_exp(int n_hi, logic [1:0] tsel, string req);
        exp_t e;
        int lim;
        lim = 6 + 2 * int'(tsel);
        if (32 - n_hi <= lim)   begin e.value = 1'b1; e.err = 1'b0; end
        else if (n_hi <= lim)   begin e.value = 1'b0; e.err = 1'b0; end
        else                    begin e.value = 1'b0; e.err = 1'b1; end
        e.cyc = cyc + 1;
        e.req = req;
        sb.push_back(e);
    endtask

    // Driver: one full window, expected verdict pushed to the scoreboard
    task automatic drive_window(int n_hi, logic [1:0] tsel, int pat,
                                bit gaps, bit strobe_on_start, string req);
        @(negedge clk);
        win_start  = 1'b1;
        tol_sel    = tsel;
        smp_strobe = strobe_on_start;
        line_in    = 1'b1;
        @(negedge clk);
        win_start  = 1'b0;
        smp_strobe = 1'b0;
        for (int i = 0; i < 32; i++) begin
            line_in    = pat_bit(pat, n_hi, i);
            smp_strobe = 1'b1;
            @(negedge clk);
            smp_strobe = 1'b0;
            if (i == 31) push_exp(n_hi, tsel, req);
            if (gaps) begin
                line_in = ~pat_bit(pat, n_hi, i);
                @(negedge clk);
            end
        end
    endtask

    task automatic loose_strobes(int n, logic lvl, bit with_start);
        @(negedge clk);
        if (with_start) begin
            win_start = 1'b1;
            @(negedge clk);
            win_start = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            line_in    = lvl;
            smp_strobe = 1'b1;
            @(negedge clk);
            smp_strobe = 1'b0;
        end
    endtask

    initial begin
        rst        = 1'b1;
        line_in    = 1'b0;
        smp_strobe = 1'b0;
        win_start  = 1'b0;
        tol_sel    = 2'd0;
        repeat (3) @(negedge clk);
        vectors++;   // R1 during reset
        if (bit_valid !== 1'b0 || bit_value !== 1'b0 || bit_error !== 1'b0) begin
            misses++;
            $display("FAIL R1 outputs in reset got %0b%0b%0b expected 000",
                     bit_valid, bit_value, bit_error);
        end
        rst = 1'b0;
        @(negedge clk);
        vectors++;   // R1 after release
        if (bit_valid !== 1'b0 || bit_value !== 1'b0 || bit_error !== 1'b0) begin
            misses++;
            $display("FAIL R1 outputs after reset got %0b%0b%0b expected 000",
                     bit_valid, bit_value, bit_error);
        end

        // R2: strobes with no window start give nothing
        loose_strobes(40, 1'b1, 1'b0);
        repeat (4) @(negedge clk);

        // R4..R7 tolerance boundaries, R10 with gap toggling on code 1
        for (int t = 0; t < 4; t++) begin
            int lim;
            lim = 6 + 2 * t;
            drive_window(32 - lim,     2'(t), t % 3, t == 1, 1'b0, "R4/R5 HIGH edge");
            drive_window(32 - lim - 1, 2'(t), (t + 1) % 3, t == 1, 1'b0, "R4/R7 above HIGH edge");
            drive_window(lim,          2'(t), (t + 2) % 3, t == 1, 1'b0, "R4/R6 LOW edge");
            drive_window(lim + 1,      2'(t), t % 3, t == 1, 1'b0, "R4/R7 above LOW edge");
        end
        drive_window(32, 2'd0, 0, 1'b0, 1'b0, "R5 all high");
        drive_window(0,  2'd3, 2, 1'b0, 1'b0, "R6 all low");
        drive_window(16, 2'd3, 2, 1'b1, 1'b0, "R7/R10 even split");

        // R8: a partial window of HIGH samples is dropped on restart
        loose_strobes(20, 1'b1, 1'b1);
        drive_window(2, 2'd0, 0, 1'b0, 1'b0, "R8 restart mid window");

        // R9: strobe with start is not a sample (timing would shift by one)
        drive_window(26, 2'd0, 1, 1'b0, 1'b1, "R9 strobe on start");

        // R11: extra strobes after a full window
        drive_window(30, 2'd1, 2, 1'b0, 1'b0, "R11 window before extras");
        loose_strobes(12, 1'b0, 1'b0);
        repeat (6) @(negedge clk);

        while (sb.size() != 0) begin
            exp_t e;
            e = sb.pop_front();
            vectors++;
            misses++;
            $display("FAIL %s missing verdict got none expected %0b/%0b at %0d",
                     e.req, e.value, e.err, e.cyc);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule